// File: doc/BRIEF.md
# Circulating Character Display Memory

This block stores the characters of a text terminal screen, 25 rows of 72 six-bit characters, in serial loops with no address decoder. Each character bit has its own track: a closed loop of chained shift sections holding that bit of every character on the screen. All tracks move one place per clock, so a whole character comes out of the six track heads in parallel. The loops never stop. A character written on a given cycle takes the place of the one at the heads. It comes round again one full revolution later.

A loop position counter labels the character now at the heads. A separate scan position counter follows the display raster. To scroll, the scan counter is frozen for one row's worth of clocks while the loops keep turning. The screen image then starts one row further into the store, and a row offset records the shift, modulo the row count. No data is copied.

Top module: `char_loop_mem`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, loop_pos_o, scan_pos_o and row_ofs_o are 0 and scroll_busy_o is 0.
- R2: loop_pos_o rises by one on every clock after reset and wraps from ROWS*COLS-1 to 0.
- R3: With wr_en_i low, the character on rd_char_o appears on rd_char_o again, unchanged, exactly ROWS*COLS clocks later. All CHAR_W bits travel together.
- R4: When wr_en_i is high at a clock edge, wr_char_i replaces the character on rd_char_o at that edge. It is on rd_char_o ROWS*COLS clocks later, and no other stored character changes.
- R5: A scroll_i pulse taken while scroll_busy_o is low raises scroll_busy_o from the next cycle for exactly COLS cycles. scan_pos_o advances on the accepting edge and then holds through every busy cycle.
- R6: On the clock that ends a busy period, row_ofs_o rises by one and wraps from ROWS-1 to 0.
- R7: scroll_i is ignored while scroll_busy_o is high. The busy period is not lengthened and row_ofs_o moves only once.
- R8: Whenever scroll_busy_o is low, (scan_pos_o + row_ofs_o*COLS) mod (ROWS*COLS) equals loop_pos_o.
- R9: Reset clears the counters and the row offset but not the stored characters. The loops keep turning while reset is held.
- R10: Outside a busy period, scan_pos_o rises by one per clock and wraps from ROWS*COLS-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; every track shifts on each rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset for counters and row offset |
| wr_en_i | input | 1 | Replace the character now at the track heads |
| wr_char_i | input | CHAR_W | Character to insert |
| scroll_i | input | 1 | Request a one-row scroll |
| rd_char_o | output | CHAR_W | Character at the track heads |
| loop_pos_o | output | $clog2(ROWS*COLS) | Index of the character at the heads |
| scan_pos_o | output | $clog2(ROWS*COLS) | Display scan position |
| row_ofs_o | output | $clog2(ROWS) | Rows scrolled, modulo ROWS |
| scroll_busy_o | output | 1 | Scan position frozen for a scroll |

## Verification
A broken link between sections, or a wrong length, shows up one revolution after the loop is filled. The character that comes back on rd_char_o belongs to another slot, or it reappears at the wrong loop position. The bench models the stored characters by physical rotation, so this is caught within ROWS*COLS clocks. A hold counter that runs one cycle long or short breaks the alignment in R8. That is visible as soon as scroll_busy_o falls, and row_ofs_o steps on the wrong clock.

// File: rtl/cdm_pkg.sv
package cdm_pkg;
  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned lim);
    return (v + 1 >= lim) ? 0 : v + 1;
  endfunction
endpackage

// File: rtl/cdm_shift_section.sv
module cdm_shift_section #(
  parameter int unsigned LEN = 200
) (
  input  logic clk_i,
  input  logic d_i,
  output logic q_o
);
  logic [LEN-1:0] sr_q;

  // data is never reset: contents survive counter reset
  always_ff @(posedge clk_i) sr_q <= {d_i, sr_q[LEN-1:1]};

  assign q_o = sr_q[0];
endmodule

// File: rtl/cdm_bit_track.sv
module cdm_bit_track #(
  parameter int unsigned SECT_LEN = 200,
  parameter int unsigned SECT_N   = 9
) (
  input  logic clk_i,
  input  logic in_i,
  output logic out_o
);
  logic [SECT_N:0] link;

  assign link[SECT_N] = in_i;

  for (genvar k = 0; k < SECT_N; k++) begin : g_sect
    cdm_shift_section #(.LEN(SECT_LEN)) u_sect (
      .clk_i(clk_i),
      .d_i  (link[k+1]),
      .q_o  (link[k])
    );
  end

  assign out_o = link[0];
endmodule

// File: rtl/cdm_scan_ctrl.sv
module cdm_scan_ctrl #(
  parameter int unsigned ROWS  = 25,
  parameter int unsigned COLS  = 72,
  parameter int unsigned POS_W = 11,
  parameter int unsigned ROW_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scroll_i,
  output logic [POS_W-1:0] scan_pos_o,
  output logic [ROW_W-1:0] row_ofs_o,
  output logic             busy_o
);
  import cdm_pkg::*;

  localparam int unsigned N     = ROWS * COLS;
  localparam int unsigned HC_W  = (COLS > 2) ? $clog2(COLS) : 1;

  logic [HC_W-1:0] hcnt_q;
  logic            last_hold;

  assign last_hold = (int'(hcnt_q) == int'(COLS) - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scan_pos_o <= '0;
      row_ofs_o  <= '0;
      busy_o     <= 1'b0;
      hcnt_q     <= '0;
    end else if (busy_o) begin
      if (last_hold) begin
        busy_o    <= 1'b0;
        hcnt_q    <= '0;
        row_ofs_o <= ROW_W'(wrap_inc(int'(row_ofs_o), ROWS));
      end else begin
        hcnt_q <= hcnt_q + 1'b1;
      end
    end else begin
      scan_pos_o <= POS_W'(wrap_inc(int'(scan_pos_o), N));
      if (scroll_i) begin
        busy_o <= 1'b1;
        hcnt_q <= '0;
      end
    end
  end

  a_r5_scan_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> scan_pos_o == $past(scan_pos_o));

  a_r6_row_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> int'(row_ofs_o) ==
      ((int'($past(row_ofs_o)) == int'(ROWS) - 1) ? 0 : int'($past(row_ofs_o)) + 1));

  a_r7_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |=> $stable(row_ofs_o));

  a_r10_scan_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> int'(scan_pos_o) ==
      ((int'($past(scan_pos_o)) == int'(N) - 1) ? 0 : int'($past(scan_pos_o)) + 1));
endmodule

// File: rtl/char_loop_mem.sv
module char_loop_mem #(
  parameter int unsigned ROWS     = 25,
  parameter int unsigned COLS     = 72,
  parameter int unsigned CHAR_W   = 6,
  parameter int unsigned SECT_LEN = 200,
  localparam int unsigned N       = ROWS * COLS,
  localparam int unsigned POS_W   = $clog2(N),
  localparam int unsigned ROW_W   = (ROWS > 2) ? $clog2(ROWS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CHAR_W-1:0] wr_char_i,
  input  logic              scroll_i,
  output logic [CHAR_W-1:0] rd_char_o,
  output logic [POS_W-1:0]  loop_pos_o,
  output logic [POS_W-1:0]  scan_pos_o,
  output logic [ROW_W-1:0]  row_ofs_o,
  output logic              scroll_busy_o
);
  import cdm_pkg::*;

  localparam int unsigned SECT_N = N / SECT_LEN;

  logic [CHAR_W-1:0] feed;

  assign feed = wr_en_i ? wr_char_i : rd_char_o;

  for (genvar b = 0; b < CHAR_W; b++) begin : g_track
    cdm_bit_track #(.SECT_LEN(SECT_LEN), .SECT_N(SECT_N)) u_track (
      .clk_i(clk_i),
      .in_i (feed[b]),
      .out_o(rd_char_o[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) loop_pos_o <= '0;
    else         loop_pos_o <= POS_W'(wrap_inc(int'(loop_pos_o), N));
  end

  cdm_scan_ctrl #(.ROWS(ROWS), .COLS(COLS), .POS_W(POS_W), .ROW_W(ROW_W)) u_scan (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scroll_i  (scroll_i),
    .scan_pos_o(scan_pos_o),
    .row_ofs_o (row_ofs_o),
    .busy_o    (scroll_busy_o)
  );

  initial a_cfg_fit: assert (SECT_N * SECT_LEN == N && SECT_LEN >= 2);

  a_r2_loop_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(loop_pos_o) != int'($past(loop_pos_o)) |-> int'(loop_pos_o) ==
      ((int'($past(loop_pos_o)) == int'(N) - 1) ? 0 : int'($past(loop_pos_o)) + 1));

  a_r8_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scroll_busy_o |->
      ((int'(scan_pos_o) + int'(row_ofs_o) * int'(COLS)) % int'(N)) == int'(loop_pos_o));
endmodule

// File: tb/char_loop_mem_tb.sv
module char_loop_mem_tb;
  localparam int ROWS = 3, COLS = 4, CW = 6, SL = 3, N = ROWS * COLS;
  localparam int PW = $clog2(N), RW = 2;

  logic clk = 0, rst_n = 0, we = 0, sc = 0;
  logic [CW-1:0] wc = '0;
  logic [CW-1:0] rd;
  logic [PW-1:0] lp, sp;
  logic [RW-1:0] ro;
  logic busy;

  char_loop_mem #(.ROWS(ROWS), .COLS(COLS), .CHAR_W(CW), .SECT_LEN(SL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .wr_char_i(wc), .scroll_i(sc),
    .rd_char_o(rd), .loop_pos_o(lp), .scan_pos_o(sp), .row_ofs_o(ro),
    .scroll_busy_o(busy));

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [CW-1:0] mem [N];
  bit valid [N];
  int rot = 0, m_lp = 0, m_sp = 0, m_ro = 0, m_hc = 0;
  bit m_busy = 0;
  string dtag = "R3";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compare();
    if (valid[rot]) chk(rd == mem[rot], dtag, int'(rd), int'(mem[rot]));
    chk(int'(lp) == m_lp, "R2", int'(lp), m_lp);
    chk(int'(sp) == m_sp, "R10", int'(sp), m_sp);
    chk(int'(ro) == m_ro, "R6", int'(ro), m_ro);
    chk(busy == m_busy, "R5", int'(busy), int'(m_busy));
    if (!busy) chk(((int'(sp) + int'(ro) * COLS) % N) == int'(lp), "R8",
                   (int'(sp) + int'(ro) * COLS) % N, int'(lp));
  endtask

  // inputs set after negedge, model advanced at posedge, outputs sampled at next negedge
  task automatic cyc(input bit w, input logic [CW-1:0] c, input bit s);
    we = w; wc = c; sc = s;
    @(posedge clk);
    if (w) begin mem[rot] = c; valid[rot] = 1; end
    rot = (rot + 1) % N;
    m_lp = (m_lp + 1) % N;
    if (m_busy) begin
      if (m_hc == COLS - 1) begin m_busy = 0; m_hc = 0; m_ro = (m_ro + 1) % ROWS; end
      else m_hc++;
    end else begin
      m_sp = (m_sp + 1) % N;
      if (s) begin m_busy = 1; m_hc = 0; end
    end
    @(negedge clk);
    we = 0; sc = 0;
    compare();
  endtask

  task automatic do_reset(input int n);
    rst_n = 0; we = 0; sc = 0;
    m_lp = 0; m_sp = 0; m_ro = 0; m_hc = 0; m_busy = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); rot = (rot + 1) % N;
      @(negedge clk);
      chk(lp == 0 && sp == 0 && ro == 0 && !busy, "R1", int'(lp) + int'(sp) + int'(ro) + int'(busy), 0);
    end
    rst_n = 1;
  endtask

  initial begin
    for (int i = 0; i < N; i++) valid[i] = 0;
    @(negedge clk);
    do_reset(3);
    cyc(0, '0, 0);
    chk(lp == 1, "R1", int'(lp), 1);
    // R4: fill every slot
    dtag = "R4";
    for (int i = 0; i < N; i++) cyc(1, CW'((i * 13 + 7) % 64), 0);
    // R3: two revolutions of pure recirculation
    dtag = "R3";
    for (int i = 0; i < 2 * N; i++) cyc(0, '0, 0);
    // R4: overwrite one slot with all-ones and one with zero, rest untouched
    dtag = "R4";
    cyc(1, 6'h3f, 0);
    for (int i = 0; i < 4; i++) cyc(0, '0, 0);
    cyc(1, 6'h00, 0);
    for (int i = 0; i < 2 * N; i++) cyc(0, '0, 0);
    // R5/R7: scroll, then repeated requests during hold are ignored
    dtag = "R3";
    cyc(0, '0, 1);
    for (int i = 0; i < COLS; i++) cyc(0, '0, 1);
    for (int i = 0; i < 3; i++) cyc(0, '0, 0);
    chk(int'(ro) == 1, "R7", int'(ro), 1);
    // R6: scroll past the last row to wrap the offset
    for (int k = 0; k < ROWS; k++) begin
      cyc(0, '0, 1);
      for (int i = 0; i < COLS + 2; i++) cyc(0, '0, 0);
    end
    chk(int'(ro) == (1 + ROWS) % ROWS, "R6", int'(ro), (1 + ROWS) % ROWS);
    // R9: reset mid-hold; data keeps circulating
    cyc(0, '0, 1);
    cyc(0, '0, 0);
    do_reset(5);
    dtag = "R9";
    for (int i = 0; i < 2 * N; i++) cyc(1'b0, '0, 1'b0);
    // R4 after reset: write and scroll together
    dtag = "R4";
    cyc(1, 6'h15, 1);
    for (int i = 0; i < 2 * N; i++) cyc(0, '0, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule